// File: doc/BRIEF.md
# Byte-Framed Serial Port with a Shared Data Address

This block is an asynchronous serial port for a small register bus. A single data address leads to two separate byte stores. A bus write to that address goes into a transmit shifter that is loaded in parallel, and the framed byte leaves on `txd` at once. A bus read of the same address returns the receive store. The receive store is filled by a shifter that assembles a frame arriving on `rxd`, removes the start and stop bits, and keeps only the data byte. A control register enables the receiver and holds the two completion flags. A power register holds a rate-doubling bit. One interrupt line is raised while either flag is set.

The timing comes from an external `baudTick` strobe. When rate doubling is off, a divide-by-two stage turns the strobes into oversample ticks. When it is on, every strobe is an oversample tick. Each bit lasts 16 oversample ticks, so a bit lasts 32 strobes in normal mode and 16 strobes in doubled mode. The receiver checks a start bit halfway through it and samples every later bit at its centre.

Register map (2-bit address): 0 = control, 1 = data, 2 = power. Control bits: bit 0 receive-done flag, bit 1 transmit-done flag, bit 4 receive enable, all other bits read 0. Power bit 7 is rate doubling, all other bits read 0.

Top module: `serial_port`

## Requirements
- R1: After reset `txd` is high and `irq` is low. Reads of the control, data and power addresses all return 0x00.
- R2: A write to address 1 while the transmitter is idle starts a frame on the next clock. The frame is a low start bit, then the 8 data bits least significant first, then a high stop bit. Each bit lasts 32 `baudTick` strobes in normal mode, and `txd` stays high after the frame.
- R3: A write to address 1 while a frame is being sent is ignored. The frame in progress keeps its byte and no second frame follows.
- R4: The transmit-done flag (control bit 1) is set when the stop bit ends, and `irq` is high while it is set. A control write with bit 1 = 0 clears it. A control write with bit 1 = 1 leaves it unchanged.
- R5: With receive enable (control bit 4) set, a complete frame on `rxd` that has a high stop bit places its data byte where address 1 reads it. It also sets the receive-done flag (control bit 0), which raises `irq` and is cleared by a control write with bit 0 = 0.
- R6: The receive and transmit stores are independent. Writing address 1 does not change what address 1 reads.
- R7: While receive enable is 0, activity on `rxd` sets no flag and leaves the received byte unchanged.
- R8: Setting power bit 7 halves the bit time to 16 `baudTick` strobes for both directions. The bit reads back at bit 7 and is 0 after reset.
- R9: A low pulse on `rxd` that ends before the middle of a bit time is treated as noise. It does not start a reception.
- R10: A frame whose stop bit is sampled low is discarded. No flag is set and the received byte keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| baudTick | input | 1 | Rate strobe, 32 per bit normally, 16 when doubled |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | High while either completion flag is set |

## Verification
A wrong bit count or a wrong shift direction in the transmitter shows up on `txd` within one frame: a bit centre holds the wrong level, or the completion flag comes one bit early or late. A receive sequencer that is stuck or out of phase shows up as a wrong byte or a missing flag within about ten bit times of the frame. A wrong reaction to noise or to a low stop bit shows up as a flag that should not be set. A fault in the prescaler or the doubling selection moves every bit boundary, so the error appears at the first bit centre after the start bit. Every byte value is sent through a loopback from `txd` to `rxd` in doubled mode, so a mapping fault in either shifter shows up as a data mismatch.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DATA = 1;
  localparam int ADDR_PWR  = 2;

  // control register bit positions
  localparam int CTRL_RXDONE_BIT = 0;
  localparam int CTRL_TXDONE_BIT = 1;
  localparam int CTRL_RXEN_BIT   = 4;

  // power register bit position
  localparam int PWR_DOUBLE_BIT = 7;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxClr;
    logic rxShift;
    logic rxCapture;
  } strobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic osTick;
    logic txBitEnd;
    logic txLast;
    logic rxHalf;
    logic rxFull;
    logic rxLastData;
    logic rxLine;
  } dpStat_t;

endpackage

// File: rtl/serial_dp.sv
module serial_dp
  import serial_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              doubleRate,
  input  logic              rxd,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] txByte,
  output dpStat_t           stat,
  output logic              txd,
  output logic [DATA_W-1:0] rxBuf
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int OS_W       = $clog2(OS_RATE);
  localparam int TXC_W      = $clog2(FRAME_BITS);
  localparam int RXC_W      = $clog2(DATA_W);
  localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0]  OS_HALF  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [TXC_W-1:0] TX_LAST  = TXC_W'(FRAME_BITS - 1);
  localparam logic [RXC_W-1:0] RX_LAST  = RXC_W'(DATA_W - 1);

  // ---------------- prescaler ----------------
  logic preTog;
  logic osTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preTog <= 1'b0;
    else if (baudTick) preTog <= ~preTog;
  end

  assign osTick = baudTick & (doubleRate | preTog);

  // ---------------- transmit ----------------
  logic [FRAME_BITS-1:0] txSh;
  logic [OS_W-1:0]       txOs;
  logic [TXC_W-1:0]      txBitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '1;
      txOs     <= '0;
      txBitCnt <= '0;
    end else begin
      if (strb.txLoad)       txSh <= {1'b1, txByte, 1'b0};
      else if (strb.txShift) txSh <= {1'b1, txSh[FRAME_BITS-1:1]};

      if (strb.txLoad)  txOs <= '0;
      else if (osTick)  txOs <= txOs + 1'b1;

      if (strb.txLoad)       txBitCnt <= '0;
      else if (strb.txShift) txBitCnt <= txBitCnt + 1'b1;
    end
  end

  assign txd = txSh[0];

  // ---------------- receive line synchronizer ----------------
  logic rxLine;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rxd;
      end
      assign rxLine = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxd};
      end
      assign rxLine = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // ---------------- receive ----------------
  logic [OS_W-1:0]   rxOs;
  logic [RXC_W-1:0]  rxBitCnt;
  logic [DATA_W-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOs     <= '0;
      rxBitCnt <= '0;
      rxSh     <= '0;
      rxBuf    <= '0;
    end else begin
      if (strb.rxClr)  rxOs <= '0;
      else if (osTick) rxOs <= rxOs + 1'b1;

      if (strb.rxClr)        rxBitCnt <= '0;
      else if (strb.rxShift) rxBitCnt <= rxBitCnt + 1'b1;

      if (strb.rxShift)   rxSh  <= {rxLine, rxSh[DATA_W-1:1]};
      if (strb.rxCapture) rxBuf <= rxSh;
    end
  end

  // ---------------- status to control ----------------
  always_comb begin
    stat.osTick     = osTick;
    stat.txBitEnd   = osTick && (txOs == OS_LAST);
    stat.txLast     = (txBitCnt == TX_LAST);
    stat.rxHalf     = osTick && (rxOs == OS_HALF);
    stat.rxFull     = osTick && (rxOs == OS_LAST);
    stat.rxLastData = (rxBitCnt == RX_LAST);
    stat.rxLine     = rxLine;
  end

endmodule

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  dpStat_t           stat,
  input  logic [DATA_W-1:0] rxBuf,
  output strobe_t           strb,
  output logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              doubleRate,
  output logic              rxEnable,
  output logic              txDoneFlag,
  output logic              rxDoneFlag
);

  logic     txBusy;
  rxState_t rxState, rxNext;
  logic     wrCtrl, wrData, wrPwr;

  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrData = busWrEn && (busAddr == ADDR_W'(ADDR_DATA));
  assign wrPwr  = busWrEn && (busAddr == ADDR_W'(ADDR_PWR));
  assign txByte = busWrData;

  // strobe generation and receive sequencing
  always_comb begin
    strb         = '0;
    strb.txLoad  = wrData && !txBusy;
    strb.txShift = txBusy && stat.txBitEnd;
    rxNext       = rxState;
    if (!rxEnable) begin
      rxNext = RX_IDLE;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (!stat.rxLine) begin
            strb.rxClr = 1'b1;
            rxNext     = RX_START;
          end
        end
        RX_START: begin
          if (stat.rxHalf) begin
            if (!stat.rxLine) begin
              strb.rxClr = 1'b1;
              rxNext     = RX_DATA;
            end else begin
              rxNext = RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (stat.rxFull) begin
            strb.rxShift = 1'b1;
            if (stat.rxLastData) rxNext = RX_STOP;
          end
        end
        RX_STOP: begin
          if (stat.rxFull) begin
            strb.rxCapture = stat.rxLine;
            rxNext         = RX_IDLE;
          end
        end
        default: rxNext = RX_IDLE;
      endcase
    end
  end

  logic txDoneSet;
  assign txDoneSet = strb.txShift && stat.txLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      rxState    <= RX_IDLE;
      txDoneFlag <= 1'b0;
      rxDoneFlag <= 1'b0;
      rxEnable   <= 1'b0;
      doubleRate <= 1'b0;
    end else begin
      rxState <= rxNext;

      if (strb.txLoad)   txBusy <= 1'b1;
      else if (txDoneSet) txBusy <= 1'b0;

      txDoneFlag <= txDoneSet |
                    (txDoneFlag & ~(wrCtrl & ~busWrData[CTRL_TXDONE_BIT]));
      rxDoneFlag <= strb.rxCapture |
                    (rxDoneFlag & ~(wrCtrl & ~busWrData[CTRL_RXDONE_BIT]));

      if (wrCtrl) rxEnable   <= busWrData[CTRL_RXEN_BIT];
      if (wrPwr)  doubleRate <= busWrData[PWR_DOUBLE_BIT];
    end
  end

  // read multiplexer
  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL)) begin
      busRdData[CTRL_RXDONE_BIT] = rxDoneFlag;
      busRdData[CTRL_TXDONE_BIT] = txDoneFlag;
      busRdData[CTRL_RXEN_BIT]   = rxEnable;
    end else if (busAddr == ADDR_W'(ADDR_DATA)) begin
      busRdData = rxBuf;
    end else if (busAddr == ADDR_W'(ADDR_PWR)) begin
      busRdData[PWR_DOUBLE_BIT] = doubleRate;
    end
  end

  assign irq = txDoneFlag | rxDoneFlag;

endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              baudTick,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);

  strobe_t           strb;
  dpStat_t           stat;
  logic [DATA_W-1:0] txByte;
  logic [DATA_W-1:0] rxBuf;
  logic              doubleRate;
  logic              rxEnable;
  logic              txDoneFlag;
  logic              rxDoneFlag;

  serial_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .stat       (stat),
    .rxBuf      (rxBuf),
    .strb       (strb),
    .txByte     (txByte),
    .busRdData  (busRdData),
    .irq        (irq),
    .doubleRate (doubleRate),
    .rxEnable   (rxEnable),
    .txDoneFlag (txDoneFlag),
    .rxDoneFlag (rxDoneFlag)
  );

  serial_dp #(
    .DATA_W      (DATA_W),
    .OS_RATE     (OS_RATE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .doubleRate (doubleRate),
    .rxd        (rxd),
    .strb       (strb),
    .txByte     (txByte),
    .stat       (stat),
    .txd        (txd),
    .rxBuf      (rxBuf)
  );

endmodule

// File: rtl/serial_port_checker.sv
module serial_port_checker
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              txd,
  input logic              txLoad,
  input logic              rxCapture,
  input logic              osTick,
  input logic              doubleRate,
  input logic              rxEnable,
  input logic              txDoneFlag,
  input logic              rxDoneFlag,
  input logic [DATA_W-1:0] rxBuf
);

  // R2: a frame starts only from an idle (high) line
  p_idle_at_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> txd);

  // R4: the line is back high when the transmit flag rises
  p_stop_high_at_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDoneFlag) |-> txd);

  // R4: only a control write clears the transmit flag
  p_txdone_cleared_by_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDoneFlag) |-> $past(busWrEn && (busAddr == ADDR_W'(ADDR_CTRL))));

  // R5: only a control write clears the receive flag
  p_rxdone_cleared_by_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDoneFlag) |-> $past(busWrEn && (busAddr == ADDR_W'(ADDR_CTRL))));

  // R5: a captured byte raises the receive flag
  p_capture_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxCapture |=> rxDoneFlag);

  // R7: received byte cannot change while the receiver is disabled
  p_disabled_rx_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> $stable(rxBuf));

  // R8: without doubling, oversample ticks never come on back-to-back cycles
  p_half_rate_ticks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (osTick && !doubleRate) |=> (!osTick || doubleRate));

endmodule

bind serial_port serial_port_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .txd        (txd),
  .txLoad     (strb.txLoad),
  .rxCapture  (strb.rxCapture),
  .osTick     (stat.osTick),
  .doubleRate (doubleRate),
  .rxEnable   (rxEnable),
  .txDoneFlag (txDoneFlag),
  .rxDoneFlag (rxDoneFlag),
  .rxBuf      (rxBuf)
);

// File: tb/serial_port_bench.sv
`timescale 1ns/1ps
module serial_port_bench;

  localparam int A_CTRL = 0;
  localparam int A_DATA = 1;
  localparam int A_PWR  = 2;
  localparam int BIT_NORM = 32;
  localparam int BIT_DBL  = 16;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       baudTick = 1'b1;
  logic       rxdDrv = 1'b1;
  logic       loopMode = 1'b0;
  logic       rxdIn;
  logic       txd;
  logic       irq;

  int checks = 0;
  int errors = 0;

  assign rxdIn = loopMode ? txd : rxdDrv;

  always #5 clk = ~clk;

  serial_port u_serial_port (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .baudTick  (baudTick),
    .rxd       (rxdIn),
    .txd       (txd),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    busAddr   = 2'(a);
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [7:0] v);
    @(negedge clk);
    busAddr = 2'(a);
    #1;
    v = busRdData;
  endtask

  // send a byte and check every bit centre on txd; optional write at bit intrBit
  task automatic txFrame(input string req, input logic [7:0] b, input int bt,
                         input int intrBit, input logic [7:0] intr);
    busWrite(A_DATA, b);
    for (int k = 0; k < 10; k++) begin
      logic expBit;
      if (k == 0)                repeat (bt/2 - 1) @(negedge clk);
      else if (k == intrBit + 1) repeat (bt - 2) @(negedge clk);
      else                       repeat (bt) @(negedge clk);
      expBit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      chk(req, "txd bit", {31'b0, txd}, {31'b0, expBit});
      if (k == intrBit) busWrite(A_DATA, intr);
    end
    repeat (bt/2 + 4) @(negedge clk);
  endtask

  // drive a frame on rxd; stop bit is low for stopLow cycles when stopLow > 0
  task automatic rxFrame(input logic [7:0] b, input int bt, input int stopLow);
    @(negedge clk);
    rxdDrv = 1'b0;
    repeat (bt) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxdDrv = b[k];
      repeat (bt) @(negedge clk);
    end
    if (stopLow > 0) begin
      rxdDrv = 1'b0;
      repeat (stopLow) @(negedge clk);
    end
    rxdDrv = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pat [4];
    pat[0] = 8'hA5; pat[1] = 8'h00; pat[2] = 8'hFF; pat[3] = 8'h01;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1", "txd", {31'b0, txd}, 32'd1);
    chk("R1", "irq", {31'b0, irq}, 32'd0);
    busRead(A_CTRL, v); chk("R1", "ctrl", {24'b0, v}, 32'h00);
    busRead(A_DATA, v); chk("R1", "data", {24'b0, v}, 32'h00);
    busRead(A_PWR, v);  chk("R1", "pwr",  {24'b0, v}, 32'h00);

    // normal rate loopback with receiver on
    busWrite(A_CTRL, 8'h10);
    busRead(A_CTRL, v); chk("R5", "rx enable readback", {24'b0, v}, 32'h10);
    loopMode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      txFrame("R2", pat[i], BIT_NORM, -1, 8'h00);
      busRead(A_CTRL, v);
      chk("R4", "tx done flag", {31'b0, v[1]}, 32'd1);
      chk("R5", "rx done flag", {31'b0, v[0]}, 32'd1);
      chk("R4", "irq set", {31'b0, irq}, 32'd1);
      busRead(A_DATA, v);
      chk("R5", "received byte", {24'b0, v}, {24'b0, pat[i]});
      if (i == 0) begin
        busWrite(A_CTRL, 8'h12);
        busRead(A_CTRL, v);
        chk("R5", "rx flag cleared by 0", {31'b0, v[0]}, 32'd0);
        chk("R4", "tx flag kept by 1", {31'b0, v[1]}, 32'd1);
        chk("R4", "irq kept", {31'b0, irq}, 32'd1);
      end
      busWrite(A_CTRL, 8'h10);
      busRead(A_CTRL, v);
      chk("R4", "flags cleared", {24'b0, v}, 32'h10);
      chk("R4", "irq cleared", {31'b0, irq}, 32'd0);
    end

    // R8 doubled rate, full byte sweep through loopback
    busWrite(A_PWR, 8'h80);
    busRead(A_PWR, v); chk("R8", "pwr readback", {24'b0, v}, 32'h80);
    for (int b = 0; b < 256; b++) begin
      txFrame("R8", 8'(b), BIT_DBL, -1, 8'h00);
      busRead(A_DATA, v);
      chk("R8", "loopback byte", {24'b0, v}, b);
      busRead(A_CTRL, v);
      chk("R8", "both flags", {24'b0, v}, 32'h13);
      busWrite(A_CTRL, 8'h10);
    end
    busWrite(A_PWR, 8'h00);

    // R3 write during a frame is ignored
    txFrame("R3", 8'h3C, BIT_NORM, 3, 8'hC3);
    busRead(A_DATA, v); chk("R3", "frame kept first byte", {24'b0, v}, 32'h3C);
    busWrite(A_CTRL, 8'h10);
    for (int i = 0; i < 10; i++) begin
      repeat (40) @(negedge clk);
      chk("R3", "line stays idle", {31'b0, txd}, 32'd1);
    end
    chk("R3", "no second frame", {31'b0, irq}, 32'd0);

    // R6 independent stores, receiver fed directly
    loopMode = 1'b0;
    rxFrame(8'h5A, BIT_NORM, 0);
    busRead(A_DATA, v); chk("R5", "direct rx byte", {24'b0, v}, 32'h5A);
    busWrite(A_DATA, 8'h96);
    busRead(A_DATA, v); chk("R6", "read after write", {24'b0, v}, 32'h5A);
    repeat (11 * BIT_NORM) @(negedge clk);
    busRead(A_DATA, v); chk("R6", "read after frame", {24'b0, v}, 32'h5A);
    busWrite(A_CTRL, 8'h00);

    // R7 receiver disabled
    rxFrame(8'h77, BIT_NORM, 0);
    busRead(A_CTRL, v); chk("R7", "no flag when disabled", {24'b0, v}, 32'h00);
    busRead(A_DATA, v); chk("R7", "byte unchanged", {24'b0, v}, 32'h5A);
    chk("R7", "irq low", {31'b0, irq}, 32'd0);

    // R9 short glitch ignored, then a real frame
    busWrite(A_CTRL, 8'h10);
    @(negedge clk); rxdDrv = 1'b0;
    repeat (8) @(negedge clk); rxdDrv = 1'b1;
    repeat (12 * BIT_NORM) @(negedge clk);
    busRead(A_CTRL, v); chk("R9", "glitch sets no flag", {31'b0, v[0]}, 32'd0);
    busRead(A_DATA, v); chk("R9", "glitch keeps byte", {24'b0, v}, 32'h5A);
    rxFrame(8'h42, BIT_NORM, 0);
    busRead(A_DATA, v); chk("R9", "frame after glitch", {24'b0, v}, 32'h42);
    busWrite(A_CTRL, 8'h10);

    // R10 low stop bit discards the frame
    rxFrame(8'hE7, BIT_NORM, 24);
    repeat (12 * BIT_NORM) @(negedge clk);
    busRead(A_CTRL, v); chk("R10", "no flag on bad stop", {31'b0, v[0]}, 32'd0);
    busRead(A_DATA, v); chk("R10", "byte kept on bad stop", {24'b0, v}, 32'h42);
    chk("R10", "irq low", {31'b0, irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule